// File: doc/BRIEF.md
# Two-Event Classification Detector

This block follows the power-sourcing side's probing of a powered device through a set of digitized range flags for the input voltage. The flags are produced upstream by comparators: under the reset level, under the mark level, inside the classification window, under the turn-off level, and over the turn-on level. From these flags the block enables the classification current sink while the input sits in the classification window. It enables the mark current sink while the input has dropped from the window to below the mark level. It counts completed classification-then-mark pairs. When the configured number of pairs has completed (two by default), it sets a sticky flag recording that the source is a higher-power (Type 2) source.

The sticky flag is reported on an active-low indicator, but only while the block is in power mode and the pass switch reports that it is fully on. Power mode is held with hysteresis: it is entered on the turn-on flag and left on the turn-off flag. Dropping out of power mode hides the flag without clearing it. Only a fall below the reset level clears the flag and the pair count. A wall adapter also drives the indicator, but not through the sticky flag, so the indicator follows the adapter signal directly. Adapter sensing counts only while the input is above the mark level.

All outputs are combinational from registered state and the present flags. A flag change that moves state is therefore visible at the outputs after the next rising clock edge. There is no data stream and no back-pressure; every pin is a plain level.

Top module: `t2c_detector`

## Requirements
- R1: `class_en` is high whenever `lvl_in_class` is high, power mode is off and no adapter is sensed; otherwise it is low.
- R2: After a classification window has been seen, a fall below the mark level raises `mark_en` from the next clock edge, while the input stays under the mark level. It is low while the input is back in the classification window, and it is never raised by a mark-level input with no preceding window.
- R3: When the input falls below the mark level for the second time (N_EVENTS times in general), each fall preceded by its own classification window, the sticky flag is set. `type2_ind_n` then reads 0 once power mode and `switch_full_on` are both high.
- R4: A single classification-and-mark pair followed by power-up leaves `type2_ind_n` at 1.
- R5: Leaving the classification window for the gap above the mark level and re-entering it does not count as a new event; the pair count advances only on a fall below the mark level.
- R6: The sticky flag survives loss of power mode while the input stays above the reset level. The indicator goes to 1 when power mode drops and back to 0 when power mode returns with the switch fully on.
- R7: `lvl_below_reset` clears the sticky flag and returns the pair count to zero, so a later single pair does not complete the sequence.
- R8: Power mode is set by `lvl_above_on`, cleared by `lvl_below_off`, and held when neither is high. While it is set, `class_en` is 0 even if `lvl_in_class` is high.
- R9: With the input above the mark level, `adapter_present` drives `type2_ind_n` to 0 and forces `class_en` to 0. It sets nothing, so the indicator returns to 1 when the adapter goes away.
- R10: With the sticky flag set and power mode on, `type2_ind_n` stays 1 until `switch_full_on` is high.
- R11: After reset, with all flags low, `class_en` and `mark_en` are 0 and `type2_ind_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lvl_below_reset | input | 1 | Input is under the reset level |
| lvl_below_mark | input | 1 | Input is under the mark level |
| lvl_in_class | input | 1 | Input is inside the classification window |
| lvl_below_off | input | 1 | Input is under the turn-off level (already deglitched) |
| lvl_above_on | input | 1 | Input is over the turn-on level |
| switch_full_on | input | 1 | Pass switch has finished inrush and is fully on |
| adapter_present | input | 1 | Wall adapter voltage sensed |
| class_en | output | 1 | Enable for the classification current sink |
| mark_en | output | 1 | Enable for the mark current sink |
| type2_ind_n | output | 1 | Active-low Type 2 / adapter indicator |

## Verification
A wrong phase register shows on `mark_en` one edge after the input falls below the mark level. A wrong pair count or sticky flag stays invisible until power mode and the fully-on switch expose it on `type2_ind_n`, which can be many cycles after the fault. The scenarios therefore power up after every sequence variant: a full pair, a single pair, a window re-entered through the gap, and a reset part way through the sequence. A stuck power-mode register shows at once on `class_en` and on the indicator. The deglitch-held case, where the window flag is present while power mode is still set, checks this.

// File: rtl/t2c_pkg.sv
package t2c_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CLS  = 2'd1,
    PH_MARK = 2'd2
  } phase_t;
endpackage

// File: rtl/t2c_pwr.sv
module t2c_pwr (
  input  logic clk,
  input  logic rst_n,
  input  logic above_on,
  input  logic below_off,
  output logic pwr_mode
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pwr_mode <= 1'b0;
    else if (above_on)  pwr_mode <= 1'b1;
    else if (below_off) pwr_mode <= 1'b0;
  end

  AST_PM_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
    above_on |=> pwr_mode); // R8
  AST_PM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!above_on && !below_off) |=> $stable(pwr_mode)); // R8
endmodule

// File: rtl/t2c_seq.sv
module t2c_seq
  import t2c_pkg::*;
#(
  parameter int N_EVENTS = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   below_reset,
  input  logic   below_mark,
  input  logic   in_cls,
  output phase_t phase,
  output logic   t2_latch
);
  localparam int CW = $clog2(N_EVENTS + 1);
  localparam logic [CW-1:0] LAST = CW'(N_EVENTS - 1);
  localparam logic [CW-1:0] FULL = CW'(N_EVENTS);

  logic [CW-1:0] pairs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      pairs    <= '0;
      t2_latch <= 1'b0;
    end else if (below_reset) begin
      phase    <= PH_IDLE;
      pairs    <= '0;
      t2_latch <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: if (in_cls) phase <= PH_CLS;
        PH_CLS: if (below_mark) begin
          phase <= PH_MARK;
          if (pairs != FULL) pairs <= pairs + CW'(1);
          if (pairs == LAST) t2_latch <= 1'b1;
        end
        PH_MARK: if (in_cls) phase <= PH_CLS;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  AST_SET_FROM_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(t2_latch) |-> ($past(phase) == PH_CLS)); // R3
  AST_RESET_LEVEL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    below_reset |=> (!t2_latch && pairs == '0)); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (t2_latch && !below_reset) |=> t2_latch); // R6
  AST_NO_COUNT_WITHOUT_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    (!below_mark && !below_reset) |=> $stable(pairs)); // R5
endmodule

// File: rtl/t2c_detector.sv
module t2c_detector
  import t2c_pkg::*;
#(
  parameter int N_EVENTS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_below_reset,
  input  logic lvl_below_mark,
  input  logic lvl_in_class,
  input  logic lvl_below_off,
  input  logic lvl_above_on,
  input  logic switch_full_on,
  input  logic adapter_present,
  output logic class_en,
  output logic mark_en,
  output logic type2_ind_n
);
  phase_t phase;
  logic   t2_latch;
  logic   pwr_mode;
  logic   adapter_seen;

  t2c_seq #(.N_EVENTS(N_EVENTS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .below_reset(lvl_below_reset),
    .below_mark (lvl_below_mark),
    .in_cls     (lvl_in_class),
    .phase      (phase),
    .t2_latch   (t2_latch)
  );

  t2c_pwr u_pwr (
    .clk      (clk),
    .rst_n    (rst_n),
    .above_on (lvl_above_on),
    .below_off(lvl_below_off),
    .pwr_mode (pwr_mode)
  );

  always_comb begin
    adapter_seen = adapter_present && !lvl_below_mark;
    class_en     = lvl_in_class && !pwr_mode && !adapter_seen;
    mark_en      = (phase == PH_MARK) && lvl_below_mark && !lvl_below_reset && !pwr_mode;
    type2_ind_n  = !((t2_latch && pwr_mode && switch_full_on) || adapter_seen);
  end

  AST_IND_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (!type2_ind_n && !adapter_present) |-> (pwr_mode && switch_full_on)); // R10
  AST_NO_CLASS_IN_POWER: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lvl_above_on) |-> !class_en); // R8
endmodule

// File: tb/sim_t2c_detector.sv
module sim_t2c_detector;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic b_rst = 0, b_mark = 0, in_cls = 0, b_off = 0, a_on = 0, sw = 0, wad = 0;
  logic class_en, mark_en, ind_n;

  typedef struct {
    logic  c;
    logic  m;
    logic  i;
    string tag;
  } exp_t;
  exp_t exq[$];

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10ns clk = ~clk;

  t2c_detector u0 (
    .clk(clk), .rst_n(rst_n),
    .lvl_below_reset(b_rst), .lvl_below_mark(b_mark), .lvl_in_class(in_cls),
    .lvl_below_off(b_off), .lvl_above_on(a_on),
    .switch_full_on(sw), .adapter_present(wad),
    .class_en(class_en), .mark_en(mark_en), .type2_ind_n(ind_n)
  );

  // levels: 0 under reset, 1 under mark, 2 gap, 3 window, 4 between window and off,
  // 5 hysteresis band, 6 over turn-on, 7 window while deglitch still holds power
  task automatic step(input int lvl, input bit s, input bit w,
                      input bit ec, input bit em, input bit ei, input string tag);
    exp_t e;
    @(negedge clk);
    b_rst  = (lvl == 0);
    b_mark = (lvl <= 1);
    in_cls = (lvl == 3) || (lvl == 7);
    b_off  = (lvl <= 4);
    a_on   = (lvl == 6);
    sw = s;
    wad = w;
    e.c = ec; e.m = em; e.i = ei; e.tag = tag;
    exq.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #5ns;
      if (exq.size() != 0) begin
        e = exq.pop_front();
        checks++;
        if (class_en !== e.c || mark_en !== e.m || ind_n !== e.i) begin
          fails++;
          $display("FAIL %s: class/mark/ind actual %b%b%b expected %b%b%b",
                   e.tag, class_en, mark_en, ind_n, e.c, e.m, e.i);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    step(0, 0, 0, 0, 0, 1, "R11 reset state");
    // full two-pair sequence
    step(1, 0, 0, 0, 0, 1, "R2 no mark without window");
    step(3, 0, 0, 1, 0, 1, "R1 window enables class");
    step(1, 0, 0, 0, 1, 1, "R2 first mark");
    step(3, 0, 0, 1, 0, 1, "R2 mark off in window");
    step(1, 0, 0, 0, 1, 1, "R3 second mark");
    step(4, 0, 0, 0, 0, 1, "R3 rising");
    step(6, 0, 0, 0, 0, 1, "R10 switch not on");
    step(6, 1, 0, 0, 0, 0, "R3 indicator active");
    step(5, 1, 0, 0, 0, 0, "R8 hysteresis hold");
    step(7, 1, 0, 0, 0, 0, "R8 class off in power");
    step(4, 1, 0, 0, 0, 1, "R6 power lost");
    step(6, 0, 0, 0, 0, 1, "R10 switch off again");
    step(6, 1, 0, 0, 0, 0, "R6 flag survives");
    step(4, 0, 0, 0, 0, 1, "R8 power off");
    step(0, 0, 0, 0, 0, 1, "R7 reset level");
    step(6, 1, 0, 0, 0, 1, "R7 flag cleared");
    step(4, 0, 0, 0, 0, 1, "R8 off");
    step(0, 0, 0, 0, 0, 1, "R7 idle");
    // single pair then power
    step(3, 0, 0, 1, 0, 1, "R4 window");
    step(1, 0, 0, 0, 1, 1, "R4 mark");
    step(4, 0, 0, 0, 0, 1, "R4 rise");
    step(6, 1, 0, 0, 0, 1, "R4 single pair no flag");
    step(0, 0, 0, 0, 0, 1, "R4 clear");
    // window re-entered through gap
    step(3, 0, 0, 1, 0, 1, "R5 window");
    step(2, 0, 0, 0, 0, 1, "R5 gap");
    step(3, 0, 0, 1, 0, 1, "R5 window again");
    step(1, 0, 0, 0, 1, 1, "R5 mark");
    step(4, 0, 0, 0, 0, 1, "R5 rise");
    step(6, 1, 0, 0, 0, 1, "R5 gap not counted");
    step(0, 0, 0, 0, 0, 1, "R5 clear");
    // reset part way through sequence
    step(3, 0, 0, 1, 0, 1, "R7 window");
    step(1, 0, 0, 0, 1, 1, "R7 mark");
    step(0, 0, 0, 0, 0, 1, "R7 mid reset");
    step(3, 0, 0, 1, 0, 1, "R7 window after reset");
    step(1, 0, 0, 0, 1, 1, "R7 mark after reset");
    step(4, 0, 0, 0, 0, 1, "R7 rise");
    step(6, 1, 0, 0, 0, 1, "R7 count restarted");
    step(0, 0, 0, 0, 0, 1, "R7 clear");
    // wall adapter
    step(3, 0, 1, 0, 0, 0, "R9 adapter in window");
    step(1, 0, 1, 0, 1, 1, "R9 adapter ignored under mark");
    step(2, 0, 0, 0, 0, 1, "R9 adapter gone");
    step(4, 0, 0, 0, 0, 1, "R9 rise");
    step(6, 1, 0, 0, 0, 1, "R9 no latch");
    step(6, 1, 1, 0, 0, 0, "R9 adapter while powered");
    step(6, 1, 0, 0, 0, 1, "R9 follows adapter");
    repeat (3) @(posedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule